// File: doc/BRIEF.md
# Guarded Auxiliary Data-RAM Router

This block sits beside a small controller core and decides, for every data-memory transfer, whether the transfer is served by a 256-byte on-chip RAM or by the external memory bus. It owns that RAM. The on-chip RAM is off after reset, and all transfers then go to the external bus. The RAM is switched on by a bit in a chip-control register. That register is write-protected. It opens only after a two-byte unlock key has been written, in sequence, to a separate key register.

While the RAM is on, a transfer that uses an 8-bit register pointer always lands on-chip, whatever the upper address bits are. A transfer that uses a 16-bit pointer lands on-chip only when its upper address byte is zero. An on-chip transfer raises no external strobe. When the core is fetching from internal program memory, an on-chip transfer also leaves both external port drivers idle.

The key register is handled by a small state machine with three states. In `LK_IDLE` the register is locked. `LK_HALF` means the first key byte has been seen. `LK_OPEN` means the control register is writable. The transitions are:
- `first_ok`: `LK_IDLE` to `LK_HALF` on a key write of 87h.
- `second_ok`: `LK_HALF` to `LK_OPEN` on 59h.
- `restart`: `LK_HALF` stays in `LK_HALF` on another 87h.
- `abort`: `LK_HALF` to `LK_IDLE` on any other byte.
- `relock`: `LK_OPEN` to `LK_IDLE` on 00h.
- `hold`: any other key byte leaves `LK_IDLE` or `LK_OPEN` where it is.

Top module: `xram_router`

## Requirements
- R1: After reset the control register reads as 00h, the lock is closed (`LK_IDLE`), and every data-memory request goes to the external bus.
- R2: Writing 87h and then 59h to SFR address F6h opens the lock. A write to SFR address BFh then loads the control register, and its bit 4 set to 1 switches the on-chip RAM on.
- R3: A write to address BFh while the lock is not open leaves the control register unchanged.
- R4: In `LK_HALF`, a key byte other than 59h or 87h returns the lock to `LK_IDLE`. A repeated 87h keeps it in `LK_HALF`. In `LK_IDLE`, any byte other than 87h leaves it in `LK_IDLE`.
- R5: In `LK_OPEN`, a key write of 00h closes the lock. Any other key byte leaves the lock open.
- R6: While the RAM is on, a request with `mem_short`=1 is served on-chip for every value of `mem_addr[15:8]`.
- R7: While the RAM is on, a request with `mem_short`=0 is served on-chip when `mem_addr[15:8]` is zero, and goes to the external bus otherwise.
- R8: For an external request, `ext_rd` is 1 for a read and `ext_wr` is 1 for a write, both combinationally in the request cycle. The two strobes are never 1 together.
- R9: An on-chip request raises neither strobe. When `fetch_int`=1, it also leaves `port_drv_lo` and `port_drv_hi` at 0.
- R10: `port_drv_lo` is 1 when `fetch_int`=0 or on any external request. `port_drv_hi` is 1 when `fetch_int`=0 or on an external request with `mem_short`=0.
- R11: An on-chip write stores its byte at address `mem_addr[7:0]` on the clock edge. An on-chip read returns the byte on `rd_data` with `rd_valid`=1 one clock after the request, and `rd_data` holds that value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Special-function register write data |
| mem_req | input | 1 | Data-memory request valid |
| mem_short | input | 1 | 1 = 8-bit register pointer, 0 = 16-bit pointer |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 16 | Data-memory address |
| mem_wdata | input | 8 | Data-memory write data |
| fetch_int | input | 1 | Core is fetching from internal program memory |
| rd_data | output | 8 | On-chip read data, one clock after the request |
| rd_valid | output | 1 | One-cycle pulse marking a fresh on-chip read result |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| port_drv_lo | output | 1 | Drive enable for the low address/data port |
| port_drv_hi | output | 1 | Drive enable for the high address port |

## Verification
The bench interleaves wrong key bytes, repeated 87h bytes and 00h relocks. A lock machine that forgets to abort would accept a control write it must reject. One that relocks on any byte would drop an open lock. Register-pointer requests carry nonzero upper address bits. A router that decodes the full address would send them outside, with a stray strobe. Sixteen-bit requests at 00xxh and 01xxh probe the on-chip/external boundary. Read-after-write through the two pointer styles catches a wrong RAM index or a read returned in the wrong cycle.

// File: rtl/xr_pkg.sv
package xr_pkg;
    localparam logic [7:0] KEY_ADDR  = 8'hF6;
    localparam logic [7:0] CTRL_ADDR = 8'hBF;
    localparam logic [7:0] KEY_FIRST = 8'h87;
    localparam logic [7:0] KEY_SECOND = 8'h59;
    localparam logic [7:0] KEY_LOCK  = 8'h00;
    localparam int         EN_BIT    = 4;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;
endpackage

// File: rtl/xr_key_fsm.sv
module xr_key_fsm
    import xr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_data,
    output logic       unlocked
);
    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (key_we) begin
            unique case (state_q)
                LK_IDLE: if (key_data == KEY_FIRST) state_d = LK_HALF;   // first_ok
                LK_HALF: begin
                    if (key_data == KEY_SECOND)     state_d = LK_OPEN;   // second_ok
                    else if (key_data == KEY_FIRST) state_d = LK_HALF;   // restart
                    else                            state_d = LK_IDLE;   // abort
                end
                LK_OPEN: if (key_data == KEY_LOCK)  state_d = LK_IDLE;   // relock
                default:                            state_d = LK_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unlocked = (state_q == LK_OPEN);
    end
endmodule

// File: rtl/xr_route.sv
module xr_route (
    input  logic en,
    input  logic req,
    input  logic short_ptr,
    input  logic we,
    input  logic upper_zero,
    input  logic fetch_int,
    output logic onchip,
    output logic ext_rd,
    output logic ext_wr,
    output logic drv_lo,
    output logic drv_hi
);
    logic ext_go;

    always_comb begin
        onchip = req && en && (short_ptr || upper_zero);
        ext_go = req && !onchip;
        ext_rd = ext_go && !we;
        ext_wr = ext_go && we;
        drv_lo = !fetch_int || ext_go;
        drv_hi = !fetch_int || (ext_go && !short_ptr);
    end
endmodule

// File: rtl/xr_ram.sv
module xr_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/xram_router.sv
module xram_router
    import xr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              mem_req,
    input  logic              mem_short,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              fetch_int,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              port_drv_lo,
    output logic              port_drv_hi
);
    logic       unlocked;
    logic [7:0] ctrl_q;
    logic       key_we;
    logic       ctrl_we;
    logic       onchip;
    logic       upper_zero;

    always_comb begin
        key_we     = sfr_we && (sfr_addr == KEY_ADDR);
        ctrl_we    = sfr_we && (sfr_addr == CTRL_ADDR) && unlocked;
        upper_zero = (mem_addr[ADDR_W-1:RAM_AW] == '0);
    end

    xr_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .key_data (sfr_wdata),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= 8'h00;
        else if (ctrl_we) ctrl_q <= sfr_wdata;
    end

    xr_route u_route (
        .en         (ctrl_q[EN_BIT]),
        .req        (mem_req),
        .short_ptr  (mem_short),
        .we         (mem_we),
        .upper_zero (upper_zero),
        .fetch_int  (fetch_int),
        .onchip     (onchip),
        .ext_rd     (ext_rd),
        .ext_wr     (ext_wr),
        .drv_lo     (port_drv_lo),
        .drv_hi     (port_drv_hi)
    );

    xr_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (onchip && mem_we),
        .rd     (onchip && !mem_we),
        .addr   (mem_addr[RAM_AW-1:0]),
        .wdata  (mem_wdata),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );
endmodule

// File: rtl/xr_checks.sv
module xr_checks #(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_short,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              fetch_int,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic              port_drv_lo,
    input logic              port_drv_hi,
    input logic              rd_valid,
    input logic              onchip,
    input logic              unlocked,
    input logic [7:0]        ctrl_q
);
    AST_DISABLED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ctrl_q[xr_pkg::EN_BIT]) |-> (ext_rd || ext_wr)); // R1
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl_q)); // R3
    AST_SHORT_ONCHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_short && ctrl_q[xr_pkg::EN_BIT]) |-> (!ext_rd && !ext_wr)); // R6
    AST_HIGH_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_short && (mem_addr[ADDR_W-1:RAM_AW] != '0)) |-> (ext_rd || ext_wr)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr)); // R8
    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (onchip && fetch_int) |-> (!ext_rd && !ext_wr && !port_drv_lo && !port_drv_hi)); // R9
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (onchip && !mem_we) |=> rd_valid); // R11
endmodule

bind xram_router xr_checks #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_short   (mem_short),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .fetch_int   (fetch_int),
    .ext_rd      (ext_rd),
    .ext_wr      (ext_wr),
    .port_drv_lo (port_drv_lo),
    .port_drv_hi (port_drv_hi),
    .rd_valid    (rd_valid),
    .onchip      (onchip),
    .unlocked    (unlocked),
    .ctrl_q      (ctrl_q)
);

// File: tb/sim_xram_router.sv
module sim_xram_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        mem_req = 1'b0;
    logic        mem_short = 1'b0;
    logic        mem_we = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        fetch_int = 1'b1;
    logic [7:0]  rd_data;
    logic        rd_valid, ext_rd, ext_wr, port_drv_lo, port_drv_hi;

    int checks = 0;
    int errors = 0;

    // bench model
    int         mkey = 0;          // 0 idle, 1 half, 2 open
    logic [7:0] mctrl = 8'h00;
    logic [7:0] mmem [256];
    bit         mval [256];

    always #4 clk = ~clk;   // 125 MHz

    xram_router u0 (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .mem_req(mem_req), .mem_short(mem_short),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fetch_int(fetch_int), .rd_data(rd_data), .rd_valid(rd_valid),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .port_drv_lo(port_drv_lo),
        .port_drv_hi(port_drv_hi)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int key_next(input int s, input logic [7:0] d);
        if (s == 0) return (d == 8'h87) ? 1 : 0;
        if (s == 1) return (d == 8'h59) ? 2 : (d == 8'h87) ? 1 : 0;
        return (d == 8'h00) ? 0 : 2;
    endfunction

    task automatic cyc(input bit sw, input logic [7:0] sa, input logic [7:0] sd,
                       input bit rq, input bit sh, input bit w, input logic [15:0] a,
                       input logic [7:0] wd, input bit fi, input string tag);
        bit oc, erv;
        logic [7:0] erd;
        @(negedge clk);
        sfr_we = sw; sfr_addr = sa; sfr_wdata = sd;
        mem_req = rq; mem_short = sh; mem_we = w; mem_addr = a; mem_wdata = wd; fetch_int = fi;
        #1;
        oc = rq && mctrl[4] && (sh || a[15:8] == 8'h00);
        check(tag, "ext_rd", {7'd0, ext_rd}, {7'd0, rq && !oc && !w});
        check(tag, "ext_wr", {7'd0, ext_wr}, {7'd0, rq && !oc && w});
        check("R9/R10", "port_drv_lo", {7'd0, port_drv_lo}, {7'd0, !fi || (rq && !oc)});
        check("R9/R10", "port_drv_hi", {7'd0, port_drv_hi}, {7'd0, !fi || (rq && !oc && !sh)});
        erv = oc && !w;
        erd = 8'h00;
        if (erv && mval[a[7:0]]) erd = mmem[a[7:0]];
        if (oc && w) begin mmem[a[7:0]] = wd; mval[a[7:0]] = 1'b1; end
        if (sw && sa == 8'hBF && mkey == 2) mctrl = sd;
        if (sw && sa == 8'hF6) mkey = key_next(mkey, sd);
        @(posedge clk); #1;
        check("R11", "rd_valid", {7'd0, rd_valid}, {7'd0, erv});
        if (erv && mval[a[7:0]]) check("R11", "rd_data", rd_data, erd);
        sfr_we = 1'b0; mem_req = 1'b0;
    endtask

    task automatic sfr(input logic [7:0] sa, input logic [7:0] sd, input string tag);
        cyc(1, sa, sd, 0, 0, 0, 16'h0, 8'h0, 1, tag);
    endtask

    task automatic acc(input bit sh, input bit w, input logic [15:0] a, input logic [7:0] wd, input string tag);
        cyc(0, 8'h00, 8'h00, 1, sh, w, a, wd, 1, tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mval[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, everything external
        acc(1, 0, 16'h0012, 8'h00, "R1");
        acc(0, 1, 16'h0005, 8'h11, "R1");
        // R3: locked write ignored, access still external
        sfr(8'hBF, 8'h10, "R3");
        acc(1, 0, 16'h0012, 8'h00, "R3");
        // R4: wrong byte aborts
        sfr(8'hF6, 8'h87, "R4"); sfr(8'hF6, 8'h11, "R4"); sfr(8'hF6, 8'h59, "R4");
        sfr(8'hBF, 8'h10, "R4");
        acc(1, 0, 16'h0012, 8'h00, "R4");
        // R4: repeated first byte, then R2 unlock
        sfr(8'hF6, 8'h87, "R4"); sfr(8'hF6, 8'h87, "R4"); sfr(8'hF6, 8'h59, "R2");
        sfr(8'hBF, 8'h10, "R2");
        // R6: short pointer with junk upper bits goes on-chip
        acc(1, 1, 16'h3412, 8'h34, "R6");
        acc(1, 0, 16'hFF12, 8'h00, "R6");
        // R7: 16-bit at 00xx on-chip, 01xx external
        acc(0, 0, 16'h0012, 8'h00, "R7");
        acc(0, 0, 16'h0112, 8'h00, "R7");
        acc(0, 1, 16'h0100, 8'h55, "R7/R8");
        // R11: back-to-back write then read
        acc(0, 1, 16'h00FF, 8'hA5, "R11");
        acc(1, 0, 16'h80FF, 8'h00, "R11");
        // R10: external fetch keeps ports driven
        cyc(0, 8'h00, 8'h00, 1, 1, 0, 16'h0012, 8'h00, 0, "R10");
        cyc(0, 8'h00, 8'h00, 0, 0, 0, 16'h0000, 8'h00, 0, "R10");
        // R5: non-zero byte keeps open; zero relocks
        sfr(8'hF6, 8'h33, "R5"); sfr(8'hBF, 8'h10, "R5");
        acc(1, 0, 16'h0012, 8'h00, "R5");
        sfr(8'hF6, 8'h00, "R5"); sfr(8'hBF, 8'h00, "R5");
        acc(1, 0, 16'h0012, 8'h00, "R5");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit sw, rq, sh, w, fi;
            logic [7:0] sa, sd, hi;
            int pick;
            sw = ($urandom % 10) < 3;
            pick = $urandom % 3;
            sa = (pick == 0) ? 8'hF6 : (pick == 1) ? 8'hBF : 8'($urandom);
            pick = $urandom % 6;
            sd = (pick == 0) ? 8'h87 : (pick == 1) ? 8'h59 : (pick == 2) ? 8'h00 :
                 (pick == 3) ? 8'h10 : (pick == 4) ? 8'hEF : 8'($urandom);
            rq = ($urandom % 10) < 7;
            sh = $urandom % 2;
            w  = $urandom % 2;
            fi = ($urandom % 8) != 0;
            hi = ($urandom % 2) ? 8'h00 : 8'($urandom);
            cyc(sw, sa, sd, rq, sh, w, {hi, 8'($urandom)}, 8'($urandom), fi, "R6/R7/R8");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule